// File: doc/BRIEF.md
# Address Attribute Breakpoint Comparator

The block holds the breakpoint state of a debug unit: a lower address bound, an upper address bound, and a 16-bit attribute register that pairs a stored value for each bus attribute bit with a per-bit ignore mask. On every processor bus cycle it checks the operand address against the inclusive range and the cycle attributes (read/write, size, transfer type, transfer modifier) against the masked stored value. It raises a one-cycle trigger when both match, the cycle is valid and triggering is enabled.

Two write ports reach the registers, each with a 4-bit register index. One is the debug side and the other is the supervisor-mode processor side. A lock bit belongs to the debug side. When it is set, processor-side writes are dropped. Reads are served on the debug side. The low five attribute bits also leave the block as an address-space selector for memory references that the debug side starts.

Top module: `attr_bkpt_cmp`

## Requirements
- R1: After reset the lower bound, upper bound, attribute register and lock bit are all zero, `trig_o` is low and `space_sel_o` is zero.
- R2: A debug write (`dbg_we_i`) updates the register selected by `dbg_idx_i` at the next rising clock edge. The indices are 0 for the lock (data bit 0), 2 for the lower bound, 3 for the upper bound and 6 for the attribute register (data bits 15:0). `dbg_rdata_o` returns the register at `dbg_idx_i` combinationally, with the lock in bit 0 and the attribute zero-extended. Any other index reads zero and is not writable.
- R3: While the lock is clear, a processor write (`cpu_we_i`) updates index 2, 3 or 6 in the same way. Processor writes to index 0 never change the lock.
- R4: While the lock is set, processor writes change no register, and debug writes still take effect.
- R5: When both ports write the same index in one cycle, the debug data is stored. When they write different indices, both writes take effect.
- R6: The address matches when lower <= `bus_addr_i` <= upper, compared as unsigned values. A lower bound above the upper bound matches no address.
- R7: The attribute register layout is: bit 15 read/write mask, bits 14:13 size mask, bits 12:11 transfer-type mask, bits 10:8 modifier mask, bit 7 read/write value, bits 6:5 size value, bits 4:3 transfer-type value, bits 2:0 modifier value. An attribute bit matches when its mask bit is set or when the bus bit equals the stored value bit.
- R8: `trig_o` is high in the cycle after a rising edge at which `bus_valid_i`, `trig_en_i`, the address match and the attribute match are all true. Otherwise it is low. The compare uses the register values held before that edge.
- R9: `space_sel_o` always equals attribute register bits 4:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dbg_we_i | input | 1 | Debug-side write strobe |
| dbg_idx_i | input | 4 | Debug-side register index (write and read) |
| dbg_wdata_i | input | ADDR_W | Debug-side write data |
| dbg_rdata_o | output | ADDR_W | Read data for `dbg_idx_i` |
| cpu_we_i | input | 1 | Processor-side write strobe |
| cpu_idx_i | input | 4 | Processor-side register index |
| cpu_wdata_i | input | ADDR_W | Processor-side write data |
| bus_valid_i | input | 1 | Bus cycle valid |
| bus_addr_i | input | ADDR_W | Operand address |
| bus_rw_i | input | 1 | Read/write attribute |
| bus_size_i | input | 2 | Size attribute |
| bus_tt_i | input | 2 | Transfer-type attribute |
| bus_tm_i | input | 3 | Transfer-modifier attribute |
| trig_en_i | input | 1 | Trigger enable |
| trig_o | output | 1 | Breakpoint trigger |
| space_sel_o | output | 5 | Address-space selector (attribute bits 4:0) |

## Verification
The bench builds the block with ADDR_W = 16, the smallest width that still holds the attribute register. At this width every mask value can be combined with every bus attribute value: all 65536 pairs are swept against one fixed stored value. Address matching is swept over the bottom and top 1024 addresses under five bound settings: a normal window, a window at zero, a window at the top of the address space, a single address, and an inverted pair. The sweeps compute the expected trigger arithmetically. Directed sequences cover lock behaviour, collisions between the two ports and the single-cycle trigger pulse.

// File: rtl/attr_bkpt_pkg.sv
package attr_bkpt_pkg;
  localparam int unsigned IDX_W = 4;

  localparam logic [IDX_W-1:0] IDX_LOCK = 4'h0;
  localparam logic [IDX_W-1:0] IDX_LO   = 4'h2;
  localparam logic [IDX_W-1:0] IDX_HI   = 4'h3;
  localparam logic [IDX_W-1:0] IDX_ATTR = 4'h6;

  typedef struct packed {
    logic       rw;
    logic [1:0] sz;
    logic [1:0] tt;
    logic [2:0] tm;
  } attr_t;

  // mask half in [15:8], value half in [7:0]
  typedef struct packed {
    attr_t msk;
    attr_t val;
  } attr_reg_t;

  localparam int unsigned ATTR_REG_W = $bits(attr_reg_t);
  localparam int unsigned SPACE_W    = 5;
endpackage

// File: rtl/bkpt_regfile.sv
module bkpt_regfile
  import attr_bkpt_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dbg_we_i,
  input  logic [IDX_W-1:0]  dbg_idx_i,
  input  logic [ADDR_W-1:0] dbg_wdata_i,
  input  logic              cpu_we_i,
  input  logic [IDX_W-1:0]  cpu_idx_i,
  input  logic [ADDR_W-1:0] cpu_wdata_i,
  output logic [ADDR_W-1:0] lo_o,
  output logic [ADDR_W-1:0] hi_o,
  output attr_reg_t         attr_o,
  output logic              lock_o,
  output logic [ADDR_W-1:0] dbg_rdata_o
);
  logic              cpu_ok;
  logic [ADDR_W-1:0] lo_q, hi_q;
  attr_reg_t         attr_q;
  logic              lock_q;

  assign cpu_ok = cpu_we_i && !lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      hi_q   <= '0;
      attr_q <= '0;
      lock_q <= 1'b0;
    end else begin
      // debug port first: it wins a same-index collision
      if (dbg_we_i && dbg_idx_i == IDX_LO)      lo_q <= dbg_wdata_i;
      else if (cpu_ok && cpu_idx_i == IDX_LO)   lo_q <= cpu_wdata_i;

      if (dbg_we_i && dbg_idx_i == IDX_HI)      hi_q <= dbg_wdata_i;
      else if (cpu_ok && cpu_idx_i == IDX_HI)   hi_q <= cpu_wdata_i;

      if (dbg_we_i && dbg_idx_i == IDX_ATTR)    attr_q <= dbg_wdata_i[ATTR_REG_W-1:0];
      else if (cpu_ok && cpu_idx_i == IDX_ATTR) attr_q <= cpu_wdata_i[ATTR_REG_W-1:0];

      if (dbg_we_i && dbg_idx_i == IDX_LOCK)    lock_q <= dbg_wdata_i[0];
    end
  end

  always_comb begin
    dbg_rdata_o = '0;
    unique case (dbg_idx_i)
      IDX_LOCK: dbg_rdata_o[0] = lock_q;
      IDX_LO:   dbg_rdata_o = lo_q;
      IDX_HI:   dbg_rdata_o = hi_q;
      IDX_ATTR: dbg_rdata_o[ATTR_REG_W-1:0] = attr_q;
      default:  dbg_rdata_o = '0;
    endcase
  end

  assign lo_o   = lo_q;
  assign hi_o   = hi_q;
  assign attr_o = attr_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/bkpt_range_match.sv
module bkpt_range_match #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  assign hit_o = (addr_i >= lo_i) && (addr_i <= hi_i);
endmodule

// File: rtl/bkpt_attr_match.sv
module bkpt_attr_match
  import attr_bkpt_pkg::*;
(
  input  attr_reg_t attr_i,
  input  attr_t     bus_i,
  output logic      match_o
);
  localparam int unsigned AW = $bits(attr_t);
  logic [AW-1:0] bit_ok;

  for (genvar b = 0; b < AW; b++) begin : g_bit
    assign bit_ok[b] = attr_i.msk[b] | ~(attr_i.val[b] ^ bus_i[b]);
  end

  assign match_o = &bit_ok;
endmodule

// File: rtl/attr_bkpt_cmp.sv
module attr_bkpt_cmp
  import attr_bkpt_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dbg_we_i,
  input  logic [3:0]        dbg_idx_i,
  input  logic [ADDR_W-1:0] dbg_wdata_i,
  output logic [ADDR_W-1:0] dbg_rdata_o,
  input  logic              cpu_we_i,
  input  logic [3:0]        cpu_idx_i,
  input  logic [ADDR_W-1:0] cpu_wdata_i,
  input  logic              bus_valid_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_rw_i,
  input  logic [1:0]        bus_size_i,
  input  logic [1:0]        bus_tt_i,
  input  logic [2:0]        bus_tm_i,
  input  logic              trig_en_i,
  output logic              trig_o,
  output logic [4:0]        space_sel_o
);
  logic [ADDR_W-1:0] lo_q, hi_q;
  attr_reg_t         attr_q;
  logic              lock_q;
  logic              range_hit, attr_hit;
  attr_t             bus_attr;
  logic              trig_q;

  bkpt_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dbg_we_i    (dbg_we_i),
    .dbg_idx_i   (dbg_idx_i),
    .dbg_wdata_i (dbg_wdata_i),
    .cpu_we_i    (cpu_we_i),
    .cpu_idx_i   (cpu_idx_i),
    .cpu_wdata_i (cpu_wdata_i),
    .lo_o        (lo_q),
    .hi_o        (hi_q),
    .attr_o      (attr_q),
    .lock_o      (lock_q),
    .dbg_rdata_o (dbg_rdata_o)
  );

  bkpt_range_match #(.ADDR_W(ADDR_W)) u_range (
    .lo_i   (lo_q),
    .hi_i   (hi_q),
    .addr_i (bus_addr_i),
    .hit_o  (range_hit)
  );

  assign bus_attr = '{rw: bus_rw_i, sz: bus_size_i, tt: bus_tt_i, tm: bus_tm_i};

  bkpt_attr_match u_attr (
    .attr_i  (attr_q),
    .bus_i   (bus_attr),
    .match_o (attr_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= bus_valid_i && trig_en_i && range_hit && attr_hit;
  end

  assign trig_o      = trig_q;
  assign space_sel_o = attr_q[SPACE_W-1:0];
endmodule

// File: rtl/attr_bkpt_chk.sv
module attr_bkpt_chk
  import attr_bkpt_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dbg_we_i,
  input logic [3:0]        dbg_idx_i,
  input logic [ADDR_W-1:0] dbg_wdata_i,
  input logic              cpu_we_i,
  input logic [3:0]        cpu_idx_i,
  input logic              bus_valid_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              trig_en_i,
  input logic              trig_o,
  input logic [4:0]        space_sel_o,
  input logic [ADDR_W-1:0] lo_q,
  input logic [ADDR_W-1:0] hi_q,
  input logic [15:0]       attr_q,
  input logic              lock_q
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R1: assert (!trig_o && lo_q == '0 && hi_q == '0 && attr_q == '0 && !lock_q);
    end
  end

  assert_trig_needs_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> $past(bus_valid_i && trig_en_i));

  assert_trig_in_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> ($past(bus_addr_i) >= $past(lo_q)) && ($past(bus_addr_i) <= $past(hi_q)));

  assert_lock_blocks_cpu_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && cpu_we_i && cpu_idx_i == IDX_LO && !dbg_we_i) |=> $stable(lo_q));

  assert_dbg_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_we_i && cpu_we_i && dbg_idx_i == IDX_ATTR && cpu_idx_i == IDX_ATTR)
      |=> attr_q == $past(dbg_wdata_i[15:0]));

  assert_space_sel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_we_i && dbg_idx_i == IDX_ATTR) |=> space_sel_o == $past(dbg_wdata_i[4:0]));
endmodule

bind attr_bkpt_cmp attr_bkpt_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dbg_we_i    (dbg_we_i),
  .dbg_idx_i   (dbg_idx_i),
  .dbg_wdata_i (dbg_wdata_i),
  .cpu_we_i    (cpu_we_i),
  .cpu_idx_i   (cpu_idx_i),
  .bus_valid_i (bus_valid_i),
  .bus_addr_i  (bus_addr_i),
  .trig_en_i   (trig_en_i),
  .trig_o      (trig_o),
  .space_sel_o (space_sel_o),
  .lo_q        (lo_q),
  .hi_q        (hi_q),
  .attr_q      (attr_q),
  .lock_q      (lock_q)
);

// File: tb/attr_bkpt_cmp_bench.sv
`timescale 1ns/1ps
module attr_bkpt_cmp_bench;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dbg_we = 1'b0;
  logic [3:0]    dbg_idx = '0;
  logic [AW-1:0] dbg_wdata = '0;
  logic [AW-1:0] dbg_rdata;
  logic          cpu_we = 1'b0;
  logic [3:0]    cpu_idx = '0;
  logic [AW-1:0] cpu_wdata = '0;
  logic          bus_valid = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_at = '0;
  logic          trig_en = 1'b0;
  logic          trig;
  logic [4:0]    space_sel;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  attr_bkpt_cmp #(.ADDR_W(AW)) u_attr_bkpt_cmp (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .dbg_we_i    (dbg_we),
    .dbg_idx_i   (dbg_idx),
    .dbg_wdata_i (dbg_wdata),
    .dbg_rdata_o (dbg_rdata),
    .cpu_we_i    (cpu_we),
    .cpu_idx_i   (cpu_idx),
    .cpu_wdata_i (cpu_wdata),
    .bus_valid_i (bus_valid),
    .bus_addr_i  (bus_addr),
    .bus_rw_i    (bus_at[7]),
    .bus_size_i  (bus_at[6:5]),
    .bus_tt_i    (bus_at[4:3]),
    .bus_tm_i    (bus_at[2:0]),
    .trig_en_i   (trig_en),
    .trig_o      (trig),
    .space_sel_o (space_sel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input string req, input logic [3:0] idx, input logic [AW-1:0] exp);
    @(negedge clk);
    dbg_idx = idx;
    #1;
    chk(req, 32'(dbg_rdata), 32'(exp));
  endtask

  task automatic wr2(input logic dw, input logic [3:0] di, input logic [AW-1:0] dd,
                     input logic cw, input logic [3:0] ci, input logic [AW-1:0] cd);
    @(negedge clk);
    dbg_we = dw; dbg_idx = di; dbg_wdata = dd;
    cpu_we = cw; cpu_idx = ci; cpu_wdata = cd;
    @(negedge clk);
    dbg_we = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic dwr(input logic [3:0] i, input logic [AW-1:0] d);
    wr2(1'b1, i, d, 1'b0, 4'h0, '0);
  endtask

  task automatic cwr(input logic [3:0] i, input logic [AW-1:0] d);
    wr2(1'b0, 4'h0, '0, 1'b1, i, d);
  endtask

  task automatic bus(input logic v, input logic en, input logic [AW-1:0] a,
                     input logic [7:0] at, input logic exp, input string req);
    @(negedge clk);
    bus_valid = v; trig_en = en; bus_addr = a; bus_at = at;
    @(posedge clk);
    #2;
    chk(req, 32'(trig), 32'(exp));
  endtask

  task automatic sweep_range(input logic [AW-1:0] lo, input logic [AW-1:0] hi);
    dwr(4'h2, lo);
    dwr(4'h3, hi);
    for (int k = 0; k < 2048; k++) begin
      logic [AW-1:0] a;
      a = (k < 1024) ? AW'(k) : AW'(65536 - 2048 + k);
      bus(1'b1, 1'b1, a, 8'h00, (a >= lo) && (a <= hi), "R6");
    end
  endtask

  initial begin
    #(200000 * 20);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 trig", 32'(trig), 0);
    chk("R1 space", 32'(space_sel), 0);
    rd("R1 lock", 4'h0, '0);
    rd("R1 lo", 4'h2, '0);
    rd("R1 hi", 4'h3, '0);
    rd("R1 attr", 4'h6, '0);
    rst_n = 1'b1;

    // R2 debug writes and readback
    dwr(4'h2, 16'h1234);
    rd("R2 lo", 4'h2, 16'h1234);
    dwr(4'h6, 16'hbeef);
    rd("R2 attr", 4'h6, 16'hbeef);
    chk("R9 space", 32'(space_sel), 32'h0f);
    dwr(4'h5, 16'hffff);
    rd("R2 unmapped", 4'h5, '0);

    // R3 processor writes while unlocked
    cwr(4'h3, 16'h5678);
    rd("R3 hi", 4'h3, 16'h5678);
    cwr(4'h0, 16'h0001);
    rd("R3 lock not cpu writable", 4'h0, '0);

    // R4 lock
    dwr(4'h0, 16'h0001);
    rd("R4 lock set", 4'h0, 16'h0001);
    cwr(4'h6, 16'h1111);
    rd("R4 cpu attr blocked", 4'h6, 16'hbeef);
    cwr(4'h2, 16'h2222);
    rd("R4 cpu lo blocked", 4'h2, 16'h1234);
    dwr(4'h6, 16'h00a3);
    rd("R4 dbg attr applies", 4'h6, 16'h00a3);
    chk("R9 space", 32'(space_sel), 32'h03);
    dwr(4'h0, 16'h0000);

    // R5 collisions
    wr2(1'b1, 4'h3, 16'haaaa, 1'b1, 4'h3, 16'h5555);
    rd("R5 same idx dbg wins", 4'h3, 16'haaaa);
    wr2(1'b1, 4'h2, 16'h0102, 1'b1, 4'h3, 16'h0304);
    rd("R5 diff idx lo", 4'h2, 16'h0102);
    rd("R5 diff idx hi", 4'h3, 16'h0304);

    // R8 gating and pulse width: full range, all attributes ignored
    dwr(4'h2, 16'h0000);
    dwr(4'h3, 16'hffff);
    dwr(4'h6, 16'hff00);
    bus(1'b1, 1'b0, 16'h0040, 8'h00, 1'b0, "R8 enable low");
    bus(1'b0, 1'b1, 16'h0040, 8'h00, 1'b0, "R8 valid low");
    bus(1'b1, 1'b1, 16'h0040, 8'h00, 1'b1, "R8 hit");
    bus(1'b0, 1'b1, 16'h0040, 8'h00, 1'b0, "R8 single pulse");
    // R8 compare uses pre-edge register values
    @(negedge clk);
    dbg_we = 1'b1; dbg_idx = 4'h3; dbg_wdata = 16'h0010;
    bus_valid = 1'b1; trig_en = 1'b1; bus_addr = 16'h0040; bus_at = 8'h00;
    @(posedge clk);
    #2;
    chk("R8 old bounds used", 32'(trig), 1);
    @(negedge clk);
    dbg_we = 1'b0;
    @(posedge clk);
    #2;
    chk("R8 new bounds used", 32'(trig), 0);

    // R6 range sweeps
    sweep_range(16'h0100, 16'h01ff);
    sweep_range(16'h0000, 16'h0005);
    sweep_range(16'hfffa, 16'hffff);
    sweep_range(16'h0050, 16'h0050);
    sweep_range(16'h0300, 16'h0200);

    // R7 exhaustive mask x attribute sweep, stored value 0xa5
    dwr(4'h2, 16'h0000);
    dwr(4'h3, 16'hffff);
    for (int m = 0; m < 256; m++) begin
      dwr(4'h6, {8'(m), 8'ha5});
      for (int at = 0; at < 256; at++) begin
        bus(1'b1, 1'b1, 16'h0777, 8'(at),
            (((8'(at) ^ 8'ha5) & ~8'(m)) == 8'h00), "R7");
      end
    end
    bus(1'b0, 1'b0, '0, '0, 1'b0, "R8 idle");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule